// File: doc/BRIEF.md
# Seven-bit odd-parity serial link

This block is a full-duplex asynchronous serial port. Its frame is one start bit, seven data bits sent least significant bit first, one odd parity bit and one stop bit. One divider derives two enables from the system clock: an oversample tick at sixteen times the bit rate and a bit tick at the bit rate itself. The bit rate defaults to 9600 baud.

A parallel controller loads the transmitter with a level handshake. The controller holds `tx_load` high while it presents a character. The frame starts only after `tx_load` falls, and `tx_ready` goes high again once the stop bit has been on the line for a full bit time.

The receiver oversamples the incoming line and strips the framing bits. It presents the received character with a ready flag that stays up until the controller acknowledges it. The transmitter computes its own parity bit. On the receive side, a parity failure does not raise a separate error flag: the character is replaced by all ones.

Top module: `serial_link7`

## Requirements
- R1: A transmitted frame is, in line order: a 0 start bit, data bit 0 through bit 6, a parity bit making the total count of ones across data and parity odd, then a 1 stop bit. Each bit lasts CLK_HZ/BAUD clock cycles, which is OVS oversample ticks.
- R2: `txd` is 1 while reset is asserted and whenever no frame is being sent.
- R3: While `tx_load` is high, `txd` stays 1. The character sent is the value on `tx_data` in the last cycle that `tx_load` was high; later changes to `tx_data` have no effect.
- R4: `tx_ready` is 1 after reset. It is 0 from the cycle after `tx_load` is first seen high until the stop bit has lasted a full bit time, and it then returns to 1.
- R5: A received frame with a 1 stop bit and correct odd parity raises `rx_ready` and presents its seven data bits on `rx_char`.
- R6: `rx_ready` stays 1 until `rx_ack` is sampled high, is 0 from the next cycle, and stays 0 until another valid frame completes.
- R7: A received frame whose data and parity bits hold an even number of ones presents 7'h7F on `rx_char` and still raises `rx_ready`.
- R8: A received frame whose stop bit reads 0 is discarded. `rx_ready` is not raised and `rx_char` keeps its previous value. The receiver hunts for a new start bit only after a fresh 1-to-0 transition on `rxd`.
- R9: A low pulse on `rxd` that has ended by the centre of the start bit (the 8th oversample tick after the falling edge) is ignored and produces no word.
- R10: After reset, `rx_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_data | input | DATA_W | Character to transmit |
| tx_load | input | 1 | Load strobe; the frame starts when it falls |
| tx_ready | output | 1 | Transmitter idle and able to take a character |
| txd | output | 1 | Serial output line, idle high |
| rxd | input | 1 | Serial input line, idle high, asynchronous |
| rx_ack | input | 1 | Acknowledge of the received character |
| rx_char | output | DATA_W | Received character, or all ones on a parity failure |
| rx_ready | output | 1 | A received character waits for acknowledge |

## Verification
The assertions assume three things about the controller. It raises `tx_load` only while `tx_ready` is high. It does not acknowledge in the same cycle that a new frame completes. It acknowledges each character before the next frame's stop bit is sampled.

The stimulus keeps within these limits. It drives every transmit load from the idle state. It waits for each frame to finish before it raises the acknowledge. It leaves a gap of idle line between received frames. With these limits, `rx_char` can change only in a cycle where `rx_ready` rises. The bench builds its incoming frames bit by bit at the nominal bit period, and it checks the outgoing line by sampling at bit centres.

// File: rtl/serial_link7_pkg.sv
// Shared state encodings for the seven-bit serial link.
// Assumes no other package in the build defines these names.
package serial_link7_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,   // waiting for a load
        TX_HOLD,   // load high, capturing the character
        TX_ARM,    // load fell, waiting for a bit tick
        TX_SHIFT   // frame on the line
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,   // hunting for a falling edge
        RX_START,  // confirming the start bit at its centre
        RX_BITS,   // sampling data and parity
        RX_STOP    // sampling the stop bit
    } rx_state_e;

endpackage

// File: rtl/serial_link7_clkgen.sv
// Divider producing an oversample enable and a bit-rate enable.
// Assumes TICK_DIV >= 1; both enables are one-cycle pulses, and the
// bit enable coincides with every OVS-th oversample enable.
module serial_link7_clkgen #(
    parameter int TICK_DIV = 651,
    parameter int OVS      = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic os_tick,
    output logic baud_tick
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int OW = $clog2(OVS);

    logic [DW-1:0] div_q;
    logic [OW-1:0] ovs_q;

    // count system clocks per oversample tick, and ticks per bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            ovs_q <= '0;
        end else if (div_q == DW'(TICK_DIV - 1)) begin
            div_q <= '0;
            ovs_q <= (ovs_q == OW'(OVS - 1)) ? '0 : ovs_q + OW'(1);
        end else begin
            div_q <= div_q + DW'(1);
        end
    end

    assign os_tick   = (div_q == DW'(TICK_DIV - 1));
    assign baud_tick = os_tick && (ovs_q == OW'(OVS - 1));
endmodule

// File: rtl/serial_link7_tx.sv
// Frame transmitter: start, data LSB first, odd parity, stop.
// Assumes load is raised only while ready is high; the character
// captured is the one present in the last cycle load was high.
module serial_link7_tx
    import serial_link7_pkg::*;
#(
    parameter int DATA_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [DATA_W-1:0] data,
    input  logic              load,
    output logic              ready,
    output logic              txd
);
    localparam int SH_W   = DATA_W + 2;          // data, parity, stop
    localparam int LAST   = DATA_W + 2;          // emissions after start
    localparam int CW     = $clog2(LAST + 1);

    tx_state_e         state;
    logic [DATA_W-1:0] hold;
    logic [SH_W-1:0]   shreg;
    logic [CW-1:0]     cnt;

    // capture on load, start on its fall, shift out on bit ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            hold  <= '0;
            shreg <= '1;
            cnt   <= '0;
            ready <= 1'b1;
            txd   <= 1'b1;
        end else begin
            case (state)
                TX_IDLE: if (load) begin
                    hold  <= data;
                    ready <= 1'b0;
                    state <= TX_HOLD;
                end
                TX_HOLD: begin
                    if (load) hold  <= data;
                    else      state <= TX_ARM;
                end
                TX_ARM: if (baud_tick) begin
                    txd   <= 1'b0;
                    shreg <= {1'b1, ~^hold, hold};
                    cnt   <= '0;
                    state <= TX_SHIFT;
                end
                TX_SHIFT: if (baud_tick) begin
                    if (cnt == CW'(LAST)) begin
                        ready <= 1'b1;
                        state <= TX_IDLE;
                    end else begin
                        txd   <= shreg[0];
                        shreg <= {1'b1, shreg[SH_W-1:1]};
                        cnt   <= cnt + CW'(1);
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_link7_rx.sv
// Oversampling frame receiver. Re-arms only on a 1-to-0 edge,
// confirms the start bit on the OVS/2-th tick, samples each later
// bit OVS ticks apart, drops frames whose stop bit reads 0.
// Assumes rxd is asynchronous; SYNC_N flops bring it in.
module serial_link7_rx
    import serial_link7_pkg::*;
#(
    parameter int DATA_W = 7,
    parameter int OVS    = 16,
    parameter int SYNC_N = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            os_tick,
    input  logic            rxd,
    input  logic            ack,
    output logic [DATA_W:0] word,
    output logic            ready
);
    localparam int OW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W + 1);

    logic [SYNC_N:0] sync_q;
    logic            rx_s, rx_fall;
    rx_state_e       state;
    logic [OW-1:0]   tcnt;
    logic [BW-1:0]   bcnt;
    logic [DATA_W:0] shreg;

    // synchronise the line, keeping one extra stage for edge detect
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_N-1:0], rxd};
    end

    assign rx_s    = sync_q[SYNC_N-1];
    assign rx_fall = sync_q[SYNC_N] && !rx_s;

    // frame state machine, word capture and ready handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            tcnt  <= '0;
            bcnt  <= '0;
            shreg <= '0;
            word  <= '0;
            ready <= 1'b0;
        end else begin
            if (ack) ready <= 1'b0;
            case (state)
                RX_IDLE: if (rx_fall) begin
                    tcnt  <= '0;
                    state <= RX_START;
                end
                RX_START: if (os_tick) begin
                    if (tcnt == OW'(OVS / 2 - 1)) begin
                        tcnt  <= '0;
                        bcnt  <= '0;
                        state <= rx_s ? RX_IDLE : RX_BITS;
                    end else begin
                        tcnt <= tcnt + OW'(1);
                    end
                end
                RX_BITS: if (os_tick) begin
                    if (tcnt == OW'(OVS - 1)) begin
                        tcnt  <= '0;
                        shreg <= {rx_s, shreg[DATA_W:1]};
                        if (bcnt == BW'(DATA_W)) state <= RX_STOP;
                        else                     bcnt  <= bcnt + BW'(1);
                    end else begin
                        tcnt <= tcnt + OW'(1);
                    end
                end
                RX_STOP: if (os_tick) begin
                    if (tcnt == OW'(OVS - 1)) begin
                        if (rx_s) begin
                            word  <= shreg;
                            ready <= 1'b1;
                        end
                        state <= RX_IDLE;
                    end else begin
                        tcnt <= tcnt + OW'(1);
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_link7_parity.sv
// Odd-parity filter: passes the character when data plus parity hold
// an odd number of ones, otherwise substitutes all ones.
// Assumes the parity bit is the top bit of the input word.
module serial_link7_parity #(
    parameter int DATA_W = 7
) (
    input  logic [DATA_W:0]   word,
    output logic [DATA_W-1:0] char_o
);
    logic odd_ok;

    // reduce and select
    always_comb begin
        odd_ok = ^word;
        char_o = odd_ok ? word[DATA_W-1:0] : '1;
    end
endmodule

// File: rtl/serial_link7.sv
// Top of the seven-bit odd-parity serial link: clock scaler,
// transmitter, receiver and parity filter.
// Assumes CLK_HZ is at least BAUD * OVS.
module serial_link7 #(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 9600,
    parameter int OVS    = 16,
    parameter int DATA_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    input  logic              rx_ack,
    output logic [DATA_W-1:0] rx_char,
    output logic              rx_ready
);
    localparam int RAW_DIV  = CLK_HZ / (BAUD * OVS);
    localparam int TICK_DIV = (RAW_DIV < 1) ? 1 : RAW_DIV;

    logic            os_tick, baud_tick;
    logic [DATA_W:0] rx_word;

    serial_link7_clkgen #(.TICK_DIV(TICK_DIV), .OVS(OVS)) u_clk (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .baud_tick(baud_tick)
    );

    serial_link7_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .data(tx_data),
        .load(tx_load), .ready(tx_ready), .txd(txd)
    );

    serial_link7_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_N(2)) u_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .ack(rx_ack), .word(rx_word), .ready(rx_ready)
    );

    serial_link7_parity #(.DATA_W(DATA_W)) u_par (
        .word(rx_word), .char_o(rx_char)
    );
endmodule

// File: rtl/serial_link7_chk.sv
// Port-level protocol checks for serial_link7, attached by bind.
// Assumes the controller loads only when idle and does not
// acknowledge in the cycle a new frame completes.
module serial_link7_chk #(
    parameter int DATA_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_load,
    input logic              tx_ready,
    input logic              txd,
    input logic              rx_ack,
    input logic [DATA_W-1:0] rx_char,
    input logic              rx_ready
);
    // R2
    idle_in_reset_chk: assert property (@(posedge clk) !rst_n |=> txd);

    // R3
    quiet_while_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> txd);

    // R4
    busy_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_ready);

    // R4
    busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> !tx_ready);

    // R6
    ready_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rx_ack) |=> rx_ready);

    // R6
    ready_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && rx_ack) |=> !rx_ready);

    // R8
    char_only_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rx_ready) |-> $stable(rx_char));
endmodule

bind serial_link7 serial_link7_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_ready(tx_ready),
    .txd(txd), .rx_ack(rx_ack), .rx_char(rx_char), .rx_ready(rx_ready)
);

// File: tb/serial_link7_tb.sv
module serial_link7_tb;
    localparam int BIT = 160;  // 1.6 MHz / 10 kbaud

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] tx_data = '0;
    logic       tx_load = 1'b0;
    logic       tx_ready, txd;
    logic       rxd = 1'b1;
    logic       rx_ack = 1'b0;
    logic [6:0] rx_char;
    logic       rx_ready;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    serial_link7 #(.CLK_HZ(1_600_000), .BAUD(10_000)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_load(tx_load),
        .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rx_ack(rx_ack),
        .rx_char(rx_char), .rx_ready(rx_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    // Transmit one character and capture the line at bit centres
    task automatic send_tx(input logic [6:0] d, input int hold_cyc);
        logic [9:0] got;
        logic [9:0] exp;
        int quiet_bad = 0;
        int wait_n = 0;
        logic rdy_mid;
        @(negedge clk);
        tx_data = d;
        tx_load = 1'b1;
        for (int i = 0; i < hold_cyc; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) quiet_bad++;
        end
        chk("R3 line quiet while load high", quiet_bad, 0);
        chk("R4 ready low while loading", tx_ready, 1'b0);
        tx_load = 1'b0;
        tx_data = ~d;  // must not affect the frame
        while (txd === 1'b1 && wait_n < 4 * BIT) begin
            @(negedge clk);
            wait_n++;
        end
        repeat (BIT / 2) @(negedge clk);
        got[0] = txd;
        for (int b = 1; b < 10; b++) begin
            repeat (BIT) @(negedge clk);
            got[b] = txd;
        end
        rdy_mid = tx_ready;
        exp = {1'b1, ~^d, d, 1'b0};
        chk("R1 R3 transmitted frame", got, exp);
        chk("R4 ready low during stop bit", rdy_mid, 1'b0);
        wait_n = 0;
        while (tx_ready !== 1'b1 && wait_n < 4 * BIT) begin
            @(negedge clk);
            wait_n++;
        end
        chk("R4 ready back after frame", tx_ready, 1'b1);
        chk("R2 line idle after frame", txd, 1'b1);
    endtask

    // Drive one incoming frame onto rxd
    task automatic send_rx(input logic [6:0] d, input logic par, input logic stop);
        logic [9:0] f;
        f = {stop, par, d, 1'b0};
        for (int b = 0; b < 10; b++) begin
            @(negedge clk);
            rxd = f[b];
            repeat (BIT - 1) @(negedge clk);
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic ack_rx();
        @(negedge clk);
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
    endtask

    initial begin
        int low_seen;
        repeat (4) @(negedge clk);
        chk("R2 txd high in reset", txd, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 ready after reset", tx_ready, 1'b1);
        chk("R10 rx_ready low after reset", rx_ready, 1'b0);
        chk("R2 txd idle after reset", txd, 1'b1);

        // transmit patterns
        send_tx(7'h41, 3);
        send_tx(7'h00, 1);
        send_tx(7'h7F, 5);
        send_tx(7'h2A, 300);

        // valid receive, held until acknowledged
        send_rx(7'h35, ~^7'h35, 1'b1);
        chk("R5 ready on valid frame", rx_ready, 1'b1);
        chk("R5 char on valid frame", rx_char, 7'h35);
        repeat (500) @(negedge clk);
        chk("R6 ready held without ack", rx_ready, 1'b1);
        ack_rx();
        chk("R6 ready cleared by ack", rx_ready, 1'b0);
        repeat (100) @(negedge clk);
        chk("R6 ready stays low", rx_ready, 1'b0);

        // parity failure
        send_rx(7'h35, ^7'h35, 1'b1);
        chk("R7 ready on parity failure", rx_ready, 1'b1);
        chk("R7 char all ones", rx_char, 7'h7F);
        ack_rx();

        // valid corner values
        send_rx(7'h00, 1'b1, 1'b1);
        chk("R5 char zero", rx_char, 7'h00);
        ack_rx();
        send_rx(7'h12, ~^7'h12, 1'b1);
        chk("R5 char 12", rx_char, 7'h12);
        ack_rx();

        // bad stop bit: discarded
        send_rx(7'h66, ~^7'h66, 1'b0);
        repeat (2 * BIT) @(negedge clk);
        chk("R8 no ready on bad stop", rx_ready, 1'b0);
        chk("R8 char unchanged", rx_char, 7'h12);

        // bad stop with line then held low: no re-arm without an edge
        for (int b = 0; b < 10; b++) begin
            @(negedge clk);
            rxd = (b == 9) ? 1'b0 : ((b == 0) ? 1'b0 : 1'b1);
            repeat (BIT - 1) @(negedge clk);
        end
        repeat (20 * BIT) @(negedge clk);
        chk("R8 no word from held-low line", rx_ready, 1'b0);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        chk("R8 still no word after release", rx_ready, 1'b0);

        // short glitch ignored
        @(negedge clk);
        rxd = 1'b0;
        repeat (30) @(negedge clk);
        rxd = 1'b1;
        low_seen = 0;
        for (int i = 0; i < 12 * BIT; i++) begin
            @(negedge clk);
            if (rx_ready) low_seen++;
        end
        chk("R9 glitch ignored", low_seen, 0);
        chk("R9 char unchanged after glitch", rx_char, 7'h12);

        // a good frame still arrives after the glitch
        send_rx(7'h5A, ~^7'h5A, 1'b1);
        chk("R5 frame after glitch", rx_char, 7'h5A);
        chk("R5 ready after glitch", rx_ready, 1'b1);
        ack_rx();

        summary();
        $finish;
    end
endmodule